// File: doc/BRIEF.md
# Bit-Serial Associative Processing Array

This block is a row of N one-bit processing elements that all execute the same micro-operation in the same clock cycle. Each element has a private bit-addressed memory, a carry flip-flop, a route register and an enable tag. Words wider than one bit are processed one bit per micro-operation, least significant bit first, under the control of an external sequencer that is not part of this block. Searches compare a broadcast bit against a stored bit in every element and drop the tag of each element that disagrees, so that later writes touch only the responders. A wired-OR of all tags tells the sequencer whether any element still responds.

Operands move between elements through the route registers. An element can read the route bit of its left neighbour, its right neighbour (both wrapping at the ends), its perfect-shuffle source, or its perfect-shuffle source with the even/odd pair exchange applied after the shuffle. Each element also knows its own position, which lets a program build per-element data and select single elements by content.

Top module: `bsa_array`

## Requirements
- R1: While reset is high and after it, every tag is 1, every memory bit, carry and route register is 0 and `any_o` is 1. `uop_ready_o` is 0 while reset is high and 1 from the first clock edge after reset is released. A micro-operation is accepted on a rising edge where `uop_valid_i` and `uop_ready_o` are both 1, and its effect is visible after that edge.
- R2: Opcode 1 (write constant) stores `uop_pat_i` into bit `uop_d_i` of every enabled element; disabled elements keep that bit.
- R3: Opcode 2 (write index) stores bit number `uop_a_i` of the element's own position (0 for the leftmost) into bit `uop_d_i` of every enabled element.
- R4: Opcode 3 (add step) writes a^b^c into bit `uop_d_i` and majority(a,b,c) into the carry, where a and b are bits `uop_a_i` and `uop_b_i` and c is the stored carry, or 0 when `uop_first_i` is 1. Issued over consecutive bit positions it adds two multi-bit fields.
- R5: Opcode 4 (search step) with `uop_first_i`=1 and `uop_keep_i`=0 sets each tag to (bit `uop_a_i` == `uop_pat_i`) in every element, whatever the tags were before. Opcode 7 sets every tag to 1.
- R6: A search step with `uop_first_i`=0, or with `uop_first_i`=1 and `uop_keep_i`=1, sets each tag to its old value AND (bit `uop_a_i` == `uop_pat_i`); no tag rises.
- R7: Disabled elements do not change their memory or their carry during write, add or route-receive operations.
- R8: Opcode 6 (route receive) stores the incoming route bit into bit `uop_d_i` of enabled elements; with `uop_route_i`=0 element i takes the route register of element i-1 (element 0 takes element N-1), with 1 it takes element i+1 (element N-1 takes element 0).
- R9: With `uop_route_i`=2 the route register of element i arrives at the element whose index is i rotated left by one bit position.
- R10: With `uop_route_i`=3 the shuffled values are then swapped between elements 2k and 2k+1.
- R11: Opcode 5 loads bit `uop_a_i` into the route register of enabled elements only; disabled elements and every other opcode leave route registers unchanged.
- R12: `any_o` equals the OR of all tags, updated on the same edge that accepts the micro-operation.
- R13: When `uop_valid_i` is 0 no state changes, whatever the other micro-operation inputs carry. Opcode 0 is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| uop_valid_i | input | 1 | Micro-operation present |
| uop_ready_o | output | 1 | Array can accept a micro-operation |
| uop_op_i | input | 3 | Opcode (0 nop, 1 write constant, 2 write index, 3 add step, 4 search step, 5 load route, 6 route receive, 7 enable all) |
| uop_route_i | input | 2 | Route source (0 left, 1 right, 2 shuffle, 3 shuffle then exchange) |
| uop_first_i | input | 1 | First step of a multi-bit operation |
| uop_keep_i | input | 1 | A first search step keeps the current tags instead of restarting |
| uop_pat_i | input | 1 | Broadcast bit for search and write constant |
| uop_a_i | input | log2(MEM_BITS) | Address of the first operand bit |
| uop_b_i | input | log2(MEM_BITS) | Address of the second operand bit |
| uop_d_i | input | log2(MEM_BITS) | Address of the destination bit |
| any_o | output | 1 | OR of all tags |

## Verification
The only way to see inside an element is the wired-OR output, so every memory bit is read back by first selecting one element through a search on its stored position and then narrowing on the bit under test; the answer on `any_o` is that element's bit. The hardest state to reach is a carry or a route register that was frozen while its element was disabled: the bench first loads distinct values, disables a subset by a search, issues operations that would overwrite them, re-enables everything and then exposes the held value through an add step of zeros or a route transfer to a neighbour. The perfect-shuffle paths are told apart from the neighbour paths by routing two one-hot markers, one of them at element 0 so that the wrap-around is also exercised.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WCONST = 3'd1,
        OP_WIDX   = 3'd2,
        OP_ADD    = 3'd3,
        OP_SRCH   = 3'd4,
        OP_LDR    = 3'd5,
        OP_ROUTE  = 3'd6,
        OP_TALL   = 3'd7
    } bsa_op_e;

    typedef enum logic [1:0] {
        RT_LEFT  = 2'd0,
        RT_RIGHT = 2'd1,
        RT_SHUF  = 2'd2,
        RT_SHUFX = 2'd3
    } bsa_rt_e;

    // index rotated right by one over w bits: the sender that reaches v through the shuffle
    function automatic int rotr_idx(int v, int w);
        if (w < 1) return v;
        return (v >> 1) | ((v & 1) << (w - 1));
    endfunction

endpackage

// File: rtl/bsa_pe.sv
module bsa_pe
    import bsa_pkg::*;
#(
    parameter int MEM_BITS = 32,
    parameter int IW       = 4,
    parameter int IDX      = 0,
    localparam int AW      = $clog2(MEM_BITS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          go_i,
    input  bsa_op_e       op_i,
    input  logic          first_i,
    input  logic          keep_i,
    input  logic          pat_i,
    input  logic [AW-1:0] a_i,
    input  logic [AW-1:0] b_i,
    input  logic [AW-1:0] d_i,
    input  logic          route_in_i,
    output logic          tag_o,
    output logic          tag_nx_o,
    output logic          rbit_o
);

    localparam logic [IW-1:0] IDX_V = IW'(IDX);

    typedef struct packed {
        logic [MEM_BITS-1:0] mem;
        logic                tag;
        logic                carry;
        logic                rbit;
    } pe_st_t;

    pe_st_t st_d, st_q;

    always_comb begin
        logic bit_a, bit_b, cin, en, idx_bit, base;
        st_d    = st_q;
        bit_a   = st_q.mem[a_i];
        bit_b   = st_q.mem[b_i];
        en      = st_q.tag;
        cin     = first_i ? 1'b0 : st_q.carry;
        base    = (first_i && !keep_i) ? 1'b1 : st_q.tag;
        idx_bit = 1'b0;
        for (int k = 0; k < IW; k++) begin
            if (a_i == AW'(k)) idx_bit = IDX_V[k];
        end
        if (go_i) begin
            case (op_i)
                OP_WCONST: if (en) st_d.mem[d_i] = pat_i;
                OP_WIDX:   if (en) st_d.mem[d_i] = idx_bit;
                OP_ADD: begin
                    if (en) begin
                        st_d.mem[d_i] = bit_a ^ bit_b ^ cin;
                        st_d.carry    = (bit_a & bit_b) | (bit_a & cin) | (bit_b & cin);
                    end
                end
                OP_SRCH:   st_d.tag = base & (bit_a == pat_i);
                OP_LDR:    if (en) st_d.rbit = bit_a;
                OP_ROUTE:  if (en) st_d.mem[d_i] = route_in_i;
                OP_TALL:   st_d.tag = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{mem: '0, tag: 1'b1, carry: 1'b0, rbit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tag_o    = st_q.tag;
    assign tag_nx_o = st_d.tag;
    assign rbit_o   = st_q.rbit;

endmodule

// File: rtl/bsa_route.sv
module bsa_route
    import bsa_pkg::*;
#(
    parameter int N       = 16,
    localparam int LGN    = $clog2(N)
) (
    input  logic [N-1:0] r_i,
    input  bsa_rt_e      sel_i,
    output logic [N-1:0] in_o
);

    for (genvar j = 0; j < N; j++) begin : g_dst
        localparam int SL = (j + N - 1) % N;
        localparam int SR = (j + 1) % N;
        localparam int SS = rotr_idx(j, LGN);
        localparam int SX = rotr_idx(j ^ 1, LGN);
        logic [3:0] cand;
        assign cand    = {r_i[SX], r_i[SS], r_i[SR], r_i[SL]};
        assign in_o[j] = cand[sel_i];
    end

endmodule

// File: rtl/bsa_array.sv
module bsa_array
    import bsa_pkg::*;
#(
    parameter int N        = 16,
    parameter int MEM_BITS = 32,
    localparam int LGN     = $clog2(N),
    localparam int AW      = $clog2(MEM_BITS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          uop_valid_i,
    output logic          uop_ready_o,
    input  logic [2:0]    uop_op_i,
    input  logic [1:0]    uop_route_i,
    input  logic          uop_first_i,
    input  logic          uop_keep_i,
    input  logic          uop_pat_i,
    input  logic [AW-1:0] uop_a_i,
    input  logic [AW-1:0] uop_b_i,
    input  logic [AW-1:0] uop_d_i,
    output logic          any_o
);

    typedef struct packed {
        logic ready;
        logic any;
    } ctl_t;

    ctl_t         ctl_d, ctl_q;
    logic         go;
    bsa_op_e      op;
    bsa_rt_e      rsel;
    logic [N-1:0] tag_q;
    logic [N-1:0] tag_nx;
    logic [N-1:0] rvec;
    logic [N-1:0] rin;

    assign go   = uop_valid_i && ctl_q.ready;
    assign op   = bsa_op_e'(uop_op_i);
    assign rsel = bsa_rt_e'(uop_route_i);

    bsa_route #(.N(N)) u_route (
        .r_i   (rvec),
        .sel_i (rsel),
        .in_o  (rin)
    );

    for (genvar i = 0; i < N; i++) begin : g_pe
        bsa_pe #(.MEM_BITS(MEM_BITS), .IW(LGN), .IDX(i)) u_pe (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .go_i       (go),
            .op_i       (op),
            .first_i    (uop_first_i),
            .keep_i     (uop_keep_i),
            .pat_i      (uop_pat_i),
            .a_i        (uop_a_i),
            .b_i        (uop_b_i),
            .d_i        (uop_d_i),
            .route_in_i (rin[i]),
            .tag_o      (tag_q[i]),
            .tag_nx_o   (tag_nx[i]),
            .rbit_o     (rvec[i])
        );
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ready = 1'b1;
        ctl_d.any   = |tag_nx;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '{ready: 1'b0, any: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign uop_ready_o = ctl_q.ready;
    assign any_o       = ctl_q.any;

endmodule

// File: rtl/bsa_array_chk.sv
module bsa_array_chk #(
    parameter int N = 16
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         uop_valid_i,
    input logic         uop_ready_o,
    input logic [2:0]   uop_op_i,
    input logic         uop_first_i,
    input logic         uop_keep_i,
    input logic [N-1:0] tag_i,
    input logic [N-1:0] r_i,
    input logic         any_o
);

    logic go;
    assign go = uop_valid_i && uop_ready_o;

    // R1
    ready_after_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> uop_ready_o);

    // R5
    enable_all_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (go && uop_op_i == 3'd7) |=> (&tag_i));

    // R6
    search_narrow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (go && uop_op_i == 3'd4 && (!uop_first_i || uop_keep_i))
        |=> ((tag_i & ~$past(tag_i)) == '0));

    // R11
    route_idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(go && uop_op_i == 3'd5) |=> $stable(r_i));

    // R11
    route_masked_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (go && uop_op_i == 3'd5) |=> (((r_i ^ $past(r_i)) & ~$past(tag_i)) == '0));

    // R12
    any_or_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        any_o == (|tag_i));

    // R13
    idle_tag_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !go |=> $stable(tag_i));

endmodule

bind bsa_array bsa_array_chk #(.N(N)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .uop_valid_i (uop_valid_i),
    .uop_ready_o (uop_ready_o),
    .uop_op_i    (uop_op_i),
    .uop_first_i (uop_first_i),
    .uop_keep_i  (uop_keep_i),
    .tag_i       (tag_q),
    .r_i         (rvec),
    .any_o       (any_o)
);

// File: tb/sim_bsa_array.sv
module sim_bsa_array;
    import bsa_pkg::*;

    localparam int N  = 8;
    localparam int M  = 32;
    localparam int AW = 5;
    localparam int IB = 29;   // position bits of each element live at IB..IB+2

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          valid = 1'b0;
    logic          ready;
    logic [2:0]    op = '0;
    logic [1:0]    rt = '0;
    logic          first = 1'b0, keep = 1'b0, pat = 1'b0;
    logic [AW-1:0] a = '0, b = '0, d = '0;
    logic          any;

    bsa_array #(.N(N), .MEM_BITS(M)) u0 (
        .clk_i(clk), .rst_i(rst), .uop_valid_i(valid), .uop_ready_o(ready),
        .uop_op_i(op), .uop_route_i(rt), .uop_first_i(first), .uop_keep_i(keep),
        .uop_pat_i(pat), .uop_a_i(a), .uop_b_i(b), .uop_d_i(d), .any_o(any)
    );

    logic [M-1:0] mem_m [N];
    logic [N-1:0] tag_m, car_m, r_m;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic int src_of(int j, logic [1:0] s);
        int x;
        case (s)
            2'd0:    return (j + N - 1) % N;
            2'd1:    return (j + 1) % N;
            2'd2:    x = j;
            default: x = j ^ 1;
        endcase
        return (x >> 1) | ((x & 1) << 2);
    endfunction

    task automatic model(logic [2:0] o, logic [1:0] r, logic f, logic k, logic p,
                         int aa, int bb, int dd);
        logic [N-1:0] rin;
        for (int j = 0; j < N; j++) rin[j] = r_m[src_of(j, r)];
        for (int e = 0; e < N; e++) begin
            logic en, ba, bbit, c;
            en   = tag_m[e];
            ba   = mem_m[e][aa];
            bbit = mem_m[e][bb];
            c    = f ? 1'b0 : car_m[e];
            case (o)
                3'd1: if (en) mem_m[e][dd] = p;
                3'd2: if (en) mem_m[e][dd] = (aa < 3) ? ((e >> aa) & 1) : 1'b0;
                3'd3: if (en) begin
                    mem_m[e][dd] = ba ^ bbit ^ c;
                    car_m[e]     = (ba & bbit) | (ba & c) | (bbit & c);
                end
                3'd4: tag_m[e] = ((f && !k) ? 1'b1 : tag_m[e]) & (ba == p);
                3'd5: if (en) r_m[e] = ba;
                3'd6: if (en) mem_m[e][dd] = rin[e];
                3'd7: tag_m[e] = 1'b1;
                default: ;
            endcase
        end
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic issue(logic [2:0] o, logic [1:0] r, logic f, logic k, logic p,
                         int aa, int bb, int dd);
        op = o; rt = r; first = f; keep = k; pat = p;
        a = AW'(aa); b = AW'(bb); d = AW'(dd);
        valid = 1'b1;
        @(posedge clk);
        model(o, r, f, k, p, aa, bb, dd);
        @(negedge clk);
        valid = 1'b0;
        check("R12", any, |tag_m, "any_o after micro-operation");
    endtask

    task automatic probe(string req, int e, int k);
        issue(OP_SRCH, 0, 1, 0, 1'((e >> 0) & 1), IB, 0, 0);
        issue(OP_SRCH, 0, 0, 0, 1'((e >> 1) & 1), IB + 1, 0, 0);
        issue(OP_SRCH, 0, 0, 0, 1'((e >> 2) & 1), IB + 2, 0, 0);
        issue(OP_SRCH, 0, 0, 0, 1'b1, k, 0, 0);
        check(req, any, mem_m[e][k], $sformatf("element %0d bit %0d", e, k));
    endtask

    task automatic probe_all(string req, int k);
        for (int e = 0; e < N; e++) probe(req, e, k);
    endtask

    task automatic t_reset();
        for (int e = 0; e < N; e++) mem_m[e] = '0;
        tag_m = '1; car_m = '0; r_m = '0;
        repeat (3) @(negedge clk);
        check("R1", ready, 1'b0, "ready during reset");
        check("R1", any, 1'b1, "any during reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1", ready, 1'b1, "ready after reset");
        check("R1", any, 1'b1, "any after reset");
    endtask

    task automatic t_widx();
        for (int j = 0; j < 3; j++) issue(OP_WIDX, 0, 0, 0, 0, j, 0, IB + j);
        for (int e = 0; e < N; e++) begin
            probe("R3", e, IB);
            probe("R3", e, IB + 2);
            probe("R1", e, 0);
        end
    endtask

    task automatic t_wconst();
        issue(OP_TALL, 0, 0, 0, 0, 0, 0, 0);
        issue(OP_SRCH, 0, 1, 0, 1, IB, 0, 0);
        issue(OP_WCONST, 0, 0, 0, 1, 0, 0, 25);
        probe_all("R2", 25);
        issue(OP_SRCH, 0, 1, 0, 1, IB + 1, 0, 0);
        issue(OP_WCONST, 0, 0, 0, 0, 0, 0, 25);
        probe_all("R2", 25);
    endtask

    task automatic t_add();
        issue(OP_TALL, 0, 0, 0, 0, 0, 0, 0);
        for (int j = 0; j < 3; j++) issue(OP_WIDX, 0, 0, 0, 0, j, 0, j);
        issue(OP_WCONST, 0, 0, 0, 1, 0, 0, 4);
        issue(OP_WCONST, 0, 0, 0, 1, 0, 0, 5);
        issue(OP_ADD, 0, 1, 0, 0, IB, IB, 26);   // leaves carry 1 in odd elements
        for (int k = 0; k < 4; k++) issue(OP_ADD, 0, (k == 0), 0, 0, k, 4 + k, 8 + k);
        for (int e = 0; e < N; e++) begin
            for (int k = 0; k < 4; k++) probe("R4", e, 8 + k);
            check("R4", 1'(((e + 3) >> 3) & 1), mem_m[e][11], $sformatf("model sum msb %0d", e));
        end
    endtask

    task automatic t_disabled();
        issue(OP_TALL, 0, 0, 0, 0, 0, 0, 0);
        issue(OP_ADD, 0, 1, 0, 0, IB, IB, 12);      // carry = position bit 0
        issue(OP_SRCH, 0, 1, 0, 0, IB + 1, 0, 0);   // enabled: 0,1,4,5
        issue(OP_ADD, 0, 1, 0, 0, 3, 3, 13);        // clears carry of enabled only
        issue(OP_WCONST, 0, 0, 0, 1, 0, 0, 14);
        issue(OP_TALL, 0, 0, 0, 0, 0, 0, 0);
        issue(OP_ADD, 0, 0, 0, 0, 3, 3, 13);        // sum shows carry: 3 and 7 only
        probe_all("R7", 13);
        probe_all("R7", 14);
    endtask

    task automatic t_search();
        issue(OP_TALL, 0, 0, 0, 0, 0, 0, 0);
        issue(OP_SRCH, 0, 1, 0, 1, IB, 0, 0);
        issue(OP_SRCH, 0, 1, 1, 1, IB + 1, 0, 0);   // keep: 3 and 7
        issue(OP_WCONST, 0, 0, 0, 1, 0, 0, 15);
        probe_all("R6", 15);
        issue(OP_SRCH, 0, 1, 1, 1, IB, 0, 0);
        issue(OP_SRCH, 0, 1, 0, 1, IB + 1, 0, 0);   // restart: 2,3,6,7
        issue(OP_WCONST, 0, 0, 0, 1, 0, 0, 16);
        probe_all("R5", 16);
        issue(OP_SRCH, 0, 1, 0, 1, 22, 0, 0);
        check("R5", any, 1'b0, "search with no match");
        issue(OP_TALL, 0, 0, 0, 0, 0, 0, 0);
        check("R5", any, 1'b1, "enable all");
    endtask

    task automatic t_route();
        issue(OP_SRCH, 0, 1, 0, 1, IB, 0, 0);
        issue(OP_SRCH, 0, 0, 0, 0, IB + 1, 0, 0);
        issue(OP_SRCH, 0, 0, 0, 1, IB + 2, 0, 0);
        issue(OP_WCONST, 0, 0, 0, 1, 0, 0, 17);     // marker at 5
        issue(OP_SRCH, 0, 1, 0, 0, IB, 0, 0);
        issue(OP_SRCH, 0, 0, 0, 0, IB + 1, 0, 0);
        issue(OP_SRCH, 0, 0, 0, 0, IB + 2, 0, 0);
        issue(OP_WCONST, 0, 0, 0, 1, 0, 0, 17);     // marker at 0
        issue(OP_TALL, 0, 0, 0, 0, 0, 0, 0);
        issue(OP_LDR, 0, 0, 0, 0, 17, 0, 0);
        for (int s = 0; s < 4; s++) issue(OP_ROUTE, 2'(s), 0, 0, 0, 0, 0, 18 + s);
        probe_all("R8", 18);
        probe_all("R8", 19);
        probe_all("R9", 20);
        probe_all("R10", 21);
        check("R9", mem_m[3][20] & mem_m[0][20], 1'b1, "model shuffle markers");
        issue(OP_SRCH, 0, 1, 0, 1, IB, 0, 0);       // odd enabled
        issue(OP_LDR, 0, 0, 0, 0, 22, 0, 0);        // 5 cleared, 0 holds 1
        issue(OP_TALL, 0, 0, 0, 0, 0, 0, 0);
        issue(OP_ROUTE, 2'd1, 0, 0, 0, 0, 0, 23);
        probe_all("R11", 23);
        check("R11", mem_m[7][23], 1'b1, "model held route bit");
    endtask

    task automatic t_idle();
        issue(OP_TALL, 0, 0, 0, 0, 0, 0, 0);
        op = OP_WCONST; pat = 1'b1; d = AW'(24); valid = 1'b0;
        repeat (2) @(negedge clk);
        probe_all("R13", 24);
        issue(OP_NOP, 0, 0, 0, 1, 0, 0, 24);
        probe_all("R13", 24);
        issue(OP_SRCH, 0, 1, 0, 1, 22, 0, 0);
        op = OP_TALL; valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R13", any, 1'b0, "idle enable-all ignored");
    endtask

    initial begin
        t_reset();
        t_widx();
        t_wconst();
        t_add();
        t_disabled();
        t_search();
        t_route();
        t_idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule